// File: doc/BRIEF.md
# Timestamp-Ordered Egress Candidate Selector

This block serves a single egress port of a packet switch. Every ingress port keeps three queues, one per transaction class: posted, non-posted and completion. The selector looks at the head of each of those queues. For each ingress port it decides whether one TLP can be offered to this egress port, and which queue that TLP comes from. The decision follows arrival order. The oldest live head of an ingress port is offered when it can be sent. A younger head may overtake it only under the relaxed-ordering rule. A separate port arbiter then chooses among the ingress ports that present a candidate.

Each head carries four items: a 16-bit timestamp of a free-running 1 µs tick, a destination port, a relaxed-ordering bit and a payload length in doublewords. The block compares each timestamp with the current tick using wrap-safe subtraction. A head older than the staleness limit is withdrawn from selection, and a registered single-cycle discard strobe tells the queue owner to drop it. The block also tells the arbiter how the TLP must travel. Cut-through applies when the ingress link is at least as wide as the egress link. Otherwise the TLP must be held until it has been received in full.

Top module: `tsch_egress_sched`

## Requirements
- R1: Among the valid, non-stale heads of one ingress port, the head with the largest age (now minus timestamp) is the oldest. On equal age the lower queue code wins: posted = 0, non-posted = 1, completion = 2. The chosen code appears on that port's 2-bit `cand_q` field.
- R2: If the oldest head cannot be sent, no candidate is offered for that ingress port, except as R5 allows. A head cannot be sent when its destination is not `EGRESS_ID`, when its credits do not fit, or when it is not yet fully received while store-and-forward is required.
- R3: A valid head whose age, computed modulo 2^16, exceeds `STALE_LIMIT` (default 50000 ticks) is stale. A stale head is never offered and never counts as the oldest.
- R4: Stale heads are reported through `discard`, bit index = ingress*3 + queue code. The strobe appears one cycle after the head becomes stale. At most one bit per ingress port is set in a cycle, the lowest queue code goes first, and a bit is never high in two consecutive cycles.
- R5: With `dro` low, a sendable posted or completion head whose relaxed-ordering bit is set may pass a blocked older head. The oldest such head is offered. A non-posted head, or a head without the bit, never passes.
- R6: With `dro` high, only the oldest head of an ingress port can ever be offered.
- R7: `cand_cut` is 1 when that ingress port's link width is at least `eg_width`. When it is 0, a head is offered only once its `hd_full` bit is set.
- R8: A head fits the credits when the header credit of its class is non-zero and the data credit of its class is at least ceil(length/4).
- R9: While `replay_full` is high, no ingress port offers a candidate. Discard strobes continue.
- R10: During and right after reset, `discard` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hd_valid | input | NIN*3 | Head present, index ingress*3+queue |
| hd_ts | input | NIN*3*TS_W | Head arrival timestamps |
| hd_dest | input | NIN*3*PORT_W | Head destination port |
| hd_ro | input | NIN*3 | Head relaxed-ordering bit |
| hd_len | input | NIN*3*LEN_W | Head payload length in doublewords |
| hd_full | input | NIN*3 | Head completely received |
| now_ts | input | TS_W | Current tick count |
| in_width | input | NIN*WID_W | Ingress link widths in lanes |
| eg_width | input | WID_W | Egress link width in lanes |
| dro | input | 1 | Force strict ordering |
| hdr_cred | input | 3*CRED_W | Egress header credits per class |
| dat_cred | input | 3*CRED_W | Egress data credits per class |
| replay_full | input | 1 | Egress replay buffer full |
| cand_valid | output | NIN | Candidate offered per ingress port |
| cand_q | output | NIN*2 | Queue code of the candidate |
| cand_cut | output | NIN | 1 = cut-through, 0 = store-and-forward |
| discard | output | NIN*3 | Stale-head drop strobes |

## Verification
Ageing and selection can happen in the same cycle. A stale posted head is dropped through its strobe while a younger non-posted head of the same port is offered. A replay-full stall can also coincide with two stale heads of one port. The bench sets up both cases. It checks that the candidate is unaffected by the stale head, that the strobes keep flowing during the stall, and that they are spread over consecutive cycles with one bit per port.

// File: rtl/tsch_pkg.sv
package tsch_pkg;
  localparam int NQ = 3;

  typedef enum logic [1:0] {
    Q_POST = 2'd0,
    Q_NONP = 2'd1,
    Q_CPL  = 2'd2
  } qkind_e;

  // data credits occupied by a payload, one credit per four doublewords
  function automatic int unsigned dw_to_units(input int unsigned dw);
    return (dw + 32'd3) / 32'd4;
  endfunction
endpackage

// File: rtl/tsch_head_eval.sv
module tsch_head_eval
  import tsch_pkg::*;
#(
  parameter int          TS_W        = 16,
  parameter int          PORT_W      = 2,
  parameter int          LEN_W       = 10,
  parameter int          CRED_W      = 12,
  parameter int unsigned STALE_LIMIT = 50000,
  parameter int          EGRESS_ID   = 0
) (
  input  logic              valid,
  input  logic [TS_W-1:0]   ts,
  input  logic [TS_W-1:0]   now,
  input  logic [PORT_W-1:0] dest,
  input  logic [LEN_W-1:0]  len,
  input  logic              full,
  input  logic              cut,
  input  logic [CRED_W-1:0] hcred,
  input  logic [CRED_W-1:0] dcred,
  output logic              live,
  output logic              stale,
  output logic              sendable,
  output logic [TS_W-1:0]   age
);
  function automatic logic [TS_W-1:0] wrap_age(input logic [TS_W-1:0] n, input logic [TS_W-1:0] t);
    return n - t;
  endfunction

  function automatic logic credit_fits(input logic [CRED_W-1:0] hc, input logic [CRED_W-1:0] dc,
                                       input logic [LEN_W-1:0] l);
    return (hc != '0) && (32'(dc) >= dw_to_units(32'(l)));
  endfunction

  logic local_dest;

  always_comb begin
    age        = wrap_age(now, ts);
    stale      = valid && (32'(age) > STALE_LIMIT);
    live       = valid && !stale;
    local_dest = (dest == PORT_W'(EGRESS_ID));
    sendable   = live && local_dest && credit_fits(hcred, dcred, len) && (cut || full);
  end
endmodule

// File: rtl/tsch_ingress_pick.sv
module tsch_ingress_pick
  import tsch_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic [NQ-1:0]      live,
  input  logic [NQ-1:0]      sendable,
  input  logic [NQ-1:0]      ro,
  input  logic [NQ*TS_W-1:0] age,
  input  logic               dro,
  input  logic               replay_full,
  output logic               cand_valid,
  output qkind_e             cand_q,
  output qkind_e             oldest_q,
  output logic               any_live
);
  logic [TS_W-1:0] best_age, pass_age;
  logic            pass_found;
  qkind_e          pass_q;

  always_comb begin
    any_live = 1'b0;
    oldest_q = Q_POST;
    best_age = '0;
    for (int q = 0; q < NQ; q++) begin
      if (live[q] && (!any_live || age[q*TS_W +: TS_W] > best_age)) begin
        any_live = 1'b1;
        best_age = age[q*TS_W +: TS_W];
        oldest_q = qkind_e'(q[1:0]);
      end
    end

    pass_found = 1'b0;
    pass_q     = Q_POST;
    pass_age   = '0;
    for (int q = 0; q < NQ; q++) begin
      if (q != int'(oldest_q) && sendable[q] && ro[q] && qkind_e'(q[1:0]) != Q_NONP &&
          (!pass_found || age[q*TS_W +: TS_W] > pass_age)) begin
        pass_found = 1'b1;
        pass_age   = age[q*TS_W +: TS_W];
        pass_q     = qkind_e'(q[1:0]);
      end
    end

    cand_valid = 1'b0;
    cand_q     = oldest_q;
    if (!replay_full && any_live) begin
      if (sendable[oldest_q]) begin
        cand_valid = 1'b1;
      end else if (!dro && pass_found) begin
        cand_valid = 1'b1;
        cand_q     = pass_q;
      end
    end
  end
endmodule

// File: rtl/tsch_stale_drop.sv
module tsch_stale_drop
  import tsch_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] stale,
  output logic [NQ-1:0] strobe
);
  logic [NQ-1:0] elig, nxt;

  always_comb begin
    elig = stale & ~strobe;
    nxt  = '0;
    for (int q = NQ - 1; q >= 0; q--) begin
      if (elig[q]) begin
        nxt    = '0;
        nxt[q] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= '0;
    else        strobe <= nxt;
  end
endmodule

// File: rtl/tsch_egress_sched.sv
module tsch_egress_sched
  import tsch_pkg::*;
#(
  parameter int          NIN         = 3,
  parameter int          TS_W        = 16,
  parameter int          PORT_W      = 2,
  parameter int          LEN_W       = 10,
  parameter int          CRED_W      = 12,
  parameter int          WID_W       = 5,
  parameter int unsigned STALE_LIMIT = 50000,
  parameter int          EGRESS_ID   = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NIN*NQ-1:0]        hd_valid,
  input  logic [NIN*NQ*TS_W-1:0]   hd_ts,
  input  logic [NIN*NQ*PORT_W-1:0] hd_dest,
  input  logic [NIN*NQ-1:0]        hd_ro,
  input  logic [NIN*NQ*LEN_W-1:0]  hd_len,
  input  logic [NIN*NQ-1:0]        hd_full,
  input  logic [TS_W-1:0]          now_ts,
  input  logic [NIN*WID_W-1:0]     in_width,
  input  logic [WID_W-1:0]         eg_width,
  input  logic                     dro,
  input  logic [NQ*CRED_W-1:0]     hdr_cred,
  input  logic [NQ*CRED_W-1:0]     dat_cred,
  input  logic                     replay_full,
  output logic [NIN-1:0]           cand_valid,
  output logic [NIN*2-1:0]         cand_q,
  output logic [NIN-1:0]           cand_cut,
  output logic [NIN*NQ-1:0]        discard
);
  localparam int NH = NIN * NQ;

  logic [NH-1:0]      live_w, stale_w, send_w;
  logic [NH*TS_W-1:0] age_w;
  logic [NIN*2-1:0]   oldest_flat;
  logic [NIN-1:0]     any_live_w;

  for (genvar i = 0; i < NIN; i++) begin : g_in
    qkind_e pick_q, old_q;

    assign cand_cut[i] = (in_width[i*WID_W +: WID_W] >= eg_width);

    for (genvar q = 0; q < NQ; q++) begin : g_q
      localparam int K = i * NQ + q;
      tsch_head_eval #(
        .TS_W(TS_W), .PORT_W(PORT_W), .LEN_W(LEN_W), .CRED_W(CRED_W),
        .STALE_LIMIT(STALE_LIMIT), .EGRESS_ID(EGRESS_ID)
      ) u_eval (
        .valid    (hd_valid[K]),
        .ts       (hd_ts[K*TS_W +: TS_W]),
        .now      (now_ts),
        .dest     (hd_dest[K*PORT_W +: PORT_W]),
        .len      (hd_len[K*LEN_W +: LEN_W]),
        .full     (hd_full[K]),
        .cut      (cand_cut[i]),
        .hcred    (hdr_cred[q*CRED_W +: CRED_W]),
        .dcred    (dat_cred[q*CRED_W +: CRED_W]),
        .live     (live_w[K]),
        .stale    (stale_w[K]),
        .sendable (send_w[K]),
        .age      (age_w[K*TS_W +: TS_W])
      );
    end

    tsch_ingress_pick #(.TS_W(TS_W)) u_pick (
      .live        (live_w[i*NQ +: NQ]),
      .sendable    (send_w[i*NQ +: NQ]),
      .ro          (hd_ro[i*NQ +: NQ]),
      .age         (age_w[i*NQ*TS_W +: NQ*TS_W]),
      .dro         (dro),
      .replay_full (replay_full),
      .cand_valid  (cand_valid[i]),
      .cand_q      (pick_q),
      .oldest_q    (old_q),
      .any_live    (any_live_w[i])
    );

    assign cand_q[i*2 +: 2]      = pick_q;
    assign oldest_flat[i*2 +: 2] = old_q;

    tsch_stale_drop u_drop (
      .clk    (clk),
      .rst_n  (rst_n),
      .stale  (stale_w[i*NQ +: NQ]),
      .strobe (discard[i*NQ +: NQ])
    );
  end
endmodule

// File: rtl/tsch_egress_sched_chk.sv
module tsch_egress_sched_chk
  import tsch_pkg::*;
#(
  parameter int NIN       = 3,
  parameter int PORT_W    = 2,
  parameter int CRED_W    = 12,
  parameter int EGRESS_ID = 0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dro,
  input logic                     replay_full,
  input logic [NIN*NQ*PORT_W-1:0] hd_dest,
  input logic [NIN*NQ-1:0]        hd_full,
  input logic [NIN*NQ-1:0]        hd_ro,
  input logic [NQ*CRED_W-1:0]     hdr_cred,
  input logic [NIN-1:0]           cand_valid,
  input logic [NIN*2-1:0]         cand_q,
  input logic [NIN-1:0]           cand_cut,
  input logic [NIN*NQ-1:0]        discard,
  input logic [NIN*2-1:0]         oldest_flat
);
  for (genvar i = 0; i < NIN; i++) begin : g_c
    logic [1:0]        cq, oq;
    logic [PORT_W-1:0] s_dest;
    logic              s_full, s_ro;
    logic [CRED_W-1:0] s_hc;

    assign cq     = cand_q[i*2 +: 2];
    assign oq     = oldest_flat[i*2 +: 2];
    assign s_dest = hd_dest[(i*NQ + int'(cq))*PORT_W +: PORT_W];
    assign s_full = hd_full[i*NQ + int'(cq)];
    assign s_ro   = hd_ro[i*NQ + int'(cq)];
    assign s_hc   = hdr_cred[int'(cq)*CRED_W +: CRED_W];

    a_r2_local_dest: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid[i] |-> s_dest == PORT_W'(EGRESS_ID));
    a_r9_replay_stall: assert property (@(posedge clk) disable iff (!rst_n)
      replay_full |-> !cand_valid[i]);
    a_r6_strict_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      (dro && cand_valid[i]) |-> cq == oq);
    a_r5_pass_rule: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid[i] && cq != oq) |-> (cq != Q_NONP && s_ro));
    a_r7_saf_whole: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid[i] && !cand_cut[i]) |-> s_full);
    a_r8_hdr_credit: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid[i] |-> s_hc != '0);
    a_r4_one_per_port: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(discard[i*NQ +: NQ]));
    for (genvar q = 0; q < NQ; q++) begin : g_p
      a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        discard[i*NQ+q] |=> !discard[i*NQ+q]);
    end
  end
endmodule

bind tsch_egress_sched tsch_egress_sched_chk #(
  .NIN(NIN), .PORT_W(PORT_W), .CRED_W(CRED_W), .EGRESS_ID(EGRESS_ID)
) u_chk (.*);

// File: tb/tsch_egress_sched_test.sv
`timescale 1ns/1ps
module tsch_egress_sched_test;
  localparam int NIN = 3, NQ = 3, TS_W = 16, PORT_W = 2, LEN_W = 10, CRED_W = 12, WID_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NIN*NQ-1:0]        hd_valid = '0, hd_ro = '0, hd_full = '0;
  logic [NIN*NQ*TS_W-1:0]   hd_ts = '0;
  logic [NIN*NQ*PORT_W-1:0] hd_dest = '0;
  logic [NIN*NQ*LEN_W-1:0]  hd_len = '0;
  logic [TS_W-1:0]          now_ts = 16'd1000;
  logic [NIN*WID_W-1:0]     in_width = '0;
  logic [WID_W-1:0]         eg_width = 5'd4;
  logic                     dro = 1'b0, replay_full = 1'b0;
  logic [NQ*CRED_W-1:0]     hdr_cred = '0, dat_cred = '0;
  logic [NIN-1:0]           cand_valid, cand_cut;
  logic [NIN*2-1:0]         cand_q;
  logic [NIN*NQ-1:0]        discard;

  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  tsch_egress_sched uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_cand(input int i, input bit v, input int q, input string tag);
    chk(cand_valid[i] == v, {tag, " valid"}, int'(cand_valid[i]), int'(v));
    if (v) chk(int'(cand_q[i*2 +: 2]) == q, {tag, " queue"}, int'(cand_q[i*2 +: 2]), q);
  endtask

  task automatic set_head(input int i, input int q, input int ts, input int dest,
                          input bit ro, input int len, input bit full);
    int k = i * NQ + q;
    hd_valid[k]                 = 1'b1;
    hd_ts[k*TS_W +: TS_W]       = ts[TS_W-1:0];
    hd_dest[k*PORT_W +: PORT_W] = dest[PORT_W-1:0];
    hd_ro[k]                    = ro;
    hd_len[k*LEN_W +: LEN_W]    = len[LEN_W-1:0];
    hd_full[k]                  = full;
  endtask

  task automatic clear_all();
    hd_valid = '0; hd_ro = '0; hd_full = '0; dro = 1'b0; replay_full = 1'b0;
    now_ts = 16'd1000; eg_width = 5'd4;
    for (int i = 0; i < NIN; i++) in_width[i*WID_W +: WID_W] = 5'd8;
    for (int q = 0; q < NQ; q++) begin
      hdr_cred[q*CRED_W +: CRED_W] = 12'd50;
      dat_cred[q*CRED_W +: CRED_W] = 12'd200;
    end
  endtask

  task automatic t_oldest();
    @(negedge clk); clear_all();
    set_head(0, 0, 100, 0, 0, 4, 1); set_head(0, 1, 90, 0, 0, 1, 1); set_head(0, 2, 95, 0, 0, 4, 1);
    set_head(1, 0, 50, 0, 0, 4, 1);  set_head(1, 2, 50, 0, 0, 4, 1);
    #1;
    expect_cand(0, 1, 1, "R1 oldest is non-posted");
    expect_cand(1, 1, 0, "R1 tie goes to posted");
    chk(cand_cut[0] == 1'b1, "R7 wide ingress cut-through", int'(cand_cut[0]), 1);
  endtask

  task automatic t_block();
    @(negedge clk); clear_all();
    set_head(0, 0, 10, 1, 0, 4, 1); set_head(0, 1, 20, 0, 0, 1, 1);
    set_head(1, 0, 10, 0, 0, 4, 1); set_head(1, 1, 20, 1, 0, 1, 1);
    #1;
    expect_cand(0, 0, 0, "R2 oldest to other egress blocks");
    expect_cand(1, 1, 0, "R2 oldest local offered");
  endtask

  task automatic t_pass();
    @(negedge clk); clear_all();
    set_head(0, 1, 10, 1, 0, 1, 1); set_head(0, 0, 20, 0, 1, 4, 1);
    set_head(1, 0, 10, 1, 0, 4, 1); set_head(1, 1, 20, 0, 1, 1, 1); set_head(1, 2, 30, 0, 0, 4, 1);
    set_head(2, 0, 10, 2, 0, 4, 1); set_head(2, 1, 20, 2, 0, 1, 1); set_head(2, 2, 30, 0, 1, 4, 1);
    #1;
    expect_cand(0, 1, 0, "R5 relaxed posted passes");
    expect_cand(1, 0, 0, "R5 non-posted and plain completion never pass");
    expect_cand(2, 1, 2, "R5 relaxed completion passes");
    dro = 1'b1; #1;
    expect_cand(0, 0, 0, "R6 strict blocks pass port0");
    expect_cand(2, 0, 0, "R6 strict blocks pass port2");
  endtask

  task automatic t_stale();
    @(negedge clk); clear_all();
    now_ts = 16'd60000;
    set_head(0, 0, 9999, 0, 0, 4, 1); set_head(0, 1, 10000, 0, 0, 1, 1);
    #1;
    expect_cand(0, 1, 1, "R3 stale head skipped, age at limit kept");
    chk(discard == '0, "R4 no strobe before edge", int'(discard), 0);
    @(negedge clk);
    chk(discard == 9'b000_000_001, "R4 strobe one cycle later", int'(discard), 1);
    expect_cand(0, 1, 1, "R3 candidate alongside discard");
    hd_valid[0] = 1'b0;
    @(negedge clk);
    chk(discard == '0, "R4 single pulse", int'(discard), 0);
    // stall and two stale heads on one port
    clear_all(); now_ts = 16'd60000; replay_full = 1'b1;
    set_head(1, 0, 1, 0, 0, 4, 1); set_head(1, 2, 2, 0, 0, 4, 1); set_head(1, 1, 59000, 0, 0, 1, 1);
    #1;
    expect_cand(1, 0, 0, "R9 replay full stalls");
    @(negedge clk);
    chk(discard == 9'b000_001_000, "R4 lowest code first during stall", int'(discard), 8);
    hd_valid[3] = 1'b0;
    @(negedge clk);
    chk(discard == 9'b000_100_000, "R4 second stale next cycle", int'(discard), 32);
    hd_valid[5] = 1'b0;
    replay_full = 1'b0; #1;
    expect_cand(1, 1, 1, "R9 offer resumes");
    // wrap-safe age
    @(negedge clk); clear_all(); now_ts = 16'd100;
    set_head(2, 0, 65000, 0, 0, 4, 1);
    #1;
    expect_cand(2, 1, 0, "R3 wrapped age is young");
    @(negedge clk);
    chk(discard == '0, "R3 wrapped age not discarded", int'(discard), 0);
  endtask

  task automatic t_saf();
    @(negedge clk); clear_all();
    in_width[0 +: WID_W] = 5'd2; in_width[WID_W +: WID_W] = 5'd4;
    set_head(0, 0, 10, 0, 0, 4, 0); set_head(1, 0, 10, 0, 0, 4, 0);
    #1;
    chk(cand_cut[0] == 1'b0, "R7 narrow ingress store-and-forward", int'(cand_cut[0]), 0);
    expect_cand(0, 0, 0, "R7 partial TLP held");
    expect_cand(1, 1, 0, "R7 equal width cuts through");
    chk(cand_cut[1] == 1'b1, "R7 equal width flag", int'(cand_cut[1]), 1);
    hd_full[0] = 1'b1; #1;
    expect_cand(0, 1, 0, "R7 full TLP offered");
  endtask

  task automatic t_credit();
    @(negedge clk); clear_all();
    set_head(0, 0, 10, 0, 0, 8, 1);
    dat_cred[0 +: CRED_W] = 12'd1; #1;
    expect_cand(0, 0, 0, "R8 one data credit short");
    dat_cred[0 +: CRED_W] = 12'd2; #1;
    expect_cand(0, 1, 0, "R8 exact data credits");
    hdr_cred[0 +: CRED_W] = 12'd0; #1;
    expect_cand(0, 0, 0, "R8 no header credit");
    hdr_cred[0 +: CRED_W] = 12'd1; dat_cred[0 +: CRED_W] = 12'd0;
    hd_len[0 +: LEN_W] = '0; #1;
    expect_cand(0, 1, 0, "R8 no payload needs no data credit");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    chk(discard == '0, "R10 strobes idle in reset", int'(discard), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(discard == '0, "R10 strobes idle after reset", int'(discard), 0);
    chk(cand_valid == '0, "R1 no heads no candidate", int'(cand_valid), 0);
    t_oldest();
    t_block();
    t_pass();
    t_stale();
    t_saf();
    t_credit();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule